// File: doc/BRIEF.md
# Vertical Sweep Burst Sequencer

This block drives the four vertical transfer phases of an interline image sensor through a fast counted burst. The burst empties the vertical registers of stale charge ahead of a still-frame readout. A one-cycle start request, taken only while the block is idle, launches the burst. A length select, sampled with the start, picks the long or the short stage count.

Each stage steps the four phases through one full rotation of four quarter-steps. In every quarter-step exactly two neighbouring phases are high. Each quarter lasts a fixed number of pixel clocks, which sets the overlap between adjacent phases. When the final stage completes, all phases drop to their idle level and a one-cycle completion pulse is issued. The sequencer then waits for the next request.

Top module: `vsweep_seq`

## Requirements
- R1: After reset, and at once while reset is asserted, `vphase_o` is 4'b0000 and `busy_o` and `done_o` are 0.
- R2: A start sampled high while idle sets `busy_o` on the next cycle, with `vphase_o` = 4'b1001 (bit 0 is phase A, bit 3 is phase D).
- R3: While busy, `vphase_o` steps through 4'b1001, 4'b0011, 4'b0110, 4'b1100 and repeats. Exactly two adjacent phases are high in every cycle.
- R4: Each quarter-step value is held for exactly QUARTER clocks (default 20). Adjacent phases therefore overlap for QUARTER clocks, and a phase edge occurs only at a quarter boundary.
- R5: With `long_sel_i` = 1 at start, the burst runs N_LONG stages (default 1368). With 0, it runs N_SHORT stages (default 684). `busy_o` stays high for stages × 4 × QUARTER cycles.
- R6: `long_sel_i` is sampled only with an accepted start. Changing it during a burst does not change that burst's length.
- R7: A start request while busy is ignored. The running burst keeps its length and phase sequence, and no extra burst follows.
- R8: In the cycle after the last quarter of the last stage, `done_o` is 1 for exactly one cycle, with `busy_o` = 0 and `vphase_o` = 4'b0000 in that same cycle.
- R9: Whenever `busy_o` is 0, `vphase_o` is 4'b0000. A start held high through the completion cycle begins a new burst one cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request, taken when idle |
| long_sel_i | input | 1 | 1 selects the long stage count, 0 the short one |
| vphase_o | output | 4 | Vertical phase levels A (bit 0) to D (bit 3) |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The checker watches, on every cycle, the two-adjacent-phases rule, the rotation order, the quarter hold length, the idle level, the entry pattern after an accepted start, and the shape of the completion pulse. Whether a burst ran the selected number of stages can only be shown by the bench's scenarios. The same holds for ignoring a select change or a repeated start mid-burst, and for the restart with start held through completion. The bench counts whole bursts against the expected cycle totals to cover these cases.

// File: rtl/vsweep_pkg.sv
package vsweep_pkg;

    typedef logic [3:0] phase_t;

    localparam phase_t PH_IDLE  = 4'b0000;
    localparam phase_t PH_FIRST = 4'b1001;

    // Two adjacent phases high, rotated left by one position per quarter-step
    function automatic phase_t quarter_pattern(input logic [1:0] q);
        logic [7:0] w;
        w = {PH_FIRST, PH_FIRST} << q;
        return w[7:4];
    endfunction

endpackage

// File: rtl/vsweep_tick.sv
module vsweep_tick #(
    parameter int QUARTER = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    output logic wrap_o
);
    localparam int TICK_W = $clog2(QUARTER + 1);
    localparam logic [TICK_W-1:0] LAST = TICK_W'(QUARTER - 1);

    typedef struct packed {
        logic [TICK_W-1:0] cnt;
    } tick_s;

    tick_s cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        wrap_o = run_i && (cur_q.cnt == LAST);
        if (clear_i) begin
            nxt_d.cnt = '0;
        end else if (run_i) begin
            nxt_d.cnt = wrap_o ? '0 : cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end
endmodule

// File: rtl/vsweep_stage_ctr.sv
module vsweep_stage_ctr #(
    parameter int N_LONG  = 1368,
    parameter int N_SHORT = 684
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clear_i,
    input  logic       long_i,
    input  logic       step_i,
    output logic [1:0] qidx_o,
    output logic       last_o
);
    localparam int STAGE_W = $clog2(N_LONG + 1);
    localparam logic [STAGE_W-1:0] LIM_LONG  = STAGE_W'(N_LONG - 1);
    localparam logic [STAGE_W-1:0] LIM_SHORT = STAGE_W'(N_SHORT - 1);

    typedef struct packed {
        logic [1:0]         qidx;
        logic [STAGE_W-1:0] stage;
        logic               long_sel;
    } ctr_s;

    ctr_s cur_q, nxt_d;
    logic [STAGE_W-1:0] limit;

    always_comb begin
        nxt_d  = cur_q;
        last_o = 1'b0;
        limit  = cur_q.long_sel ? LIM_LONG : LIM_SHORT;
        if (clear_i) begin
            nxt_d.qidx     = 2'd0;
            nxt_d.stage    = '0;
            nxt_d.long_sel = long_i;
        end else if (step_i) begin
            nxt_d.qidx = cur_q.qidx + 2'd1;
            if (cur_q.qidx == 2'd3) begin
                if (cur_q.stage == limit) begin
                    last_o      = 1'b1;
                    nxt_d.stage = '0;
                end else begin
                    nxt_d.stage = cur_q.stage + 1'b1;
                end
            end
        end
    end

    assign qidx_o = cur_q.qidx;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end
endmodule

// File: rtl/vsweep_seq.sv
module vsweep_seq
    import vsweep_pkg::*;
#(
    parameter int N_LONG  = 1368,
    parameter int N_SHORT = 684,
    parameter int QUARTER = 20
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       long_sel_i,
    output logic [3:0] vphase_o,
    output logic       busy_o,
    output logic       done_o
);
    typedef struct packed {
        logic   busy;
        logic   done;
        phase_t phase;
    } seq_s;

    seq_s cur_q, nxt_d;
    logic accept, step, finish;
    logic [1:0] qidx;

    assign accept = start_i && !cur_q.busy;

    vsweep_tick #(.QUARTER(QUARTER)) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (accept),
        .run_i   (cur_q.busy),
        .wrap_o  (step)
    );

    vsweep_stage_ctr #(.N_LONG(N_LONG), .N_SHORT(N_SHORT)) u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (accept),
        .long_i  (long_sel_i),
        .step_i  (step),
        .qidx_o  (qidx),
        .last_o  (finish)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        if (accept) begin
            nxt_d.busy  = 1'b1;
            nxt_d.phase = PH_FIRST;
        end else if (finish) begin
            nxt_d.busy  = 1'b0;
            nxt_d.done  = 1'b1;
            nxt_d.phase = PH_IDLE;
        end else if (step) begin
            nxt_d.phase = quarter_pattern(qidx + 2'd1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign vphase_o = cur_q.phase;
    assign busy_o   = cur_q.busy;
    assign done_o   = cur_q.done;
endmodule

// File: rtl/vsweep_checker.sv
module vsweep_checker #(
    parameter int QUARTER = 20
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       start_i,
    input logic [3:0] vphase_o,
    input logic       busy_o,
    input logic       done_o
);
    localparam int AGE_W = $clog2(QUARTER + 2) + 1;

    logic [AGE_W-1:0] age_q;
    logic [3:0]       last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            age_q  <= '0;
            last_q <= '0;
        end else begin
            last_q <= vphase_o;
            if (busy_o && vphase_o == last_q) age_q <= age_q + 1'b1;
            else                              age_q <= AGE_W'(1);
        end
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> vphase_o == 4'b0000); // R9

    AST_TWO_ADJACENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> ($countones(vphase_o) == 2 &&
                    (vphase_o == 4'b1001 || vphase_o == 4'b0011 ||
                     vphase_o == 4'b0110 || vphase_o == 4'b1100))); // R3

    AST_ROTATE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && vphase_o != $past(vphase_o)) |->
        vphase_o == {$past(vphase_o[2:0]), $past(vphase_o[3])}); // R3

    AST_QUARTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && vphase_o != $past(vphase_o)) |->
        age_q == AGE_W'(QUARTER)); // R4

    AST_START_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && vphase_o == 4'b1001)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && vphase_o == 4'b0000)); // R8

    AST_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o); // R8
endmodule

bind vsweep_seq vsweep_checker #(.QUARTER(QUARTER)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vphase_o (vphase_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/sim_vsweep_seq.sv
`timescale 1ns/1ps
module sim_vsweep_seq;
    localparam int NL = 6;
    localparam int NS = 3;
    localparam int Q  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic lsel = 1'b0;
    logic [3:0] ph;
    logic busy, done;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vsweep_seq #(.N_LONG(NL), .N_SHORT(NS), .QUARTER(Q)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .long_sel_i(lsel),
        .vphase_o(ph), .busy_o(busy), .done_o(done)
    );

    function automatic logic [3:0] exp_pat(input int k);
        case ((k / Q) % 4)
            0: return 4'b1001;
            1: return 4'b0011;
            2: return 4'b0110;
            default: return 4'b1100;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // {sel, poke_start_while_busy, flip_sel_midway}
    localparam logic [2:0] VEC [0:5] = '{3'b100, 3'b000, 3'b110, 3'b011, 3'b101, 3'b010};

    task automatic run_burst(input bit sel, input bit poke, input bit flip);
        int t;
        int bad_ph, bad_busy, ovl, first_bad;
        t = (sel ? NL : NS) * 4 * Q;
        bad_ph = 0; bad_busy = 0; ovl = 0; first_bad = -1;
        @(negedge clk); start = 1'b1; lsel = sel;
        @(negedge clk); start = 1'b0;
        chk(busy && ph == 4'b1001, "R2", int'(ph), 9);
        for (int k = 0; k < t; k++) begin
            if (k > 0) @(negedge clk);
            if (flip && k == 10) lsel = ~sel;
            if (poke && k == 50) start = 1'b1;
            if (poke && k == 51) start = 1'b0;
            if (ph != exp_pat(k)) begin bad_ph++; if (first_bad < 0) first_bad = k; end
            if (!busy || done) bad_busy++;
            if (k < 4 * Q && ph[0] && ph[1]) ovl++;
        end
        start = 1'b0;
        chk(bad_ph == 0, "R3", bad_ph, 0);
        chk(ovl == Q, "R4", ovl, Q);
        chk(bad_busy == 0, sel ? "R5 long" : "R5 short", bad_busy, 0);
        @(negedge clk);
        chk(!busy && done && ph == 0, "R8", {busy, done, ph}, 8'h10);
        if (flip) chk(!busy, "R6", busy, 0);
        if (poke) chk(!busy, "R7", busy, 0);
        @(negedge clk);
        chk(!done && !busy && ph == 0, poke ? "R7 no extra burst" : "R9", {busy, done, ph}, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ph == 0 && !busy && !done, "R1 in reset", {busy, done, ph}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ph == 0 && !busy && !done, "R1", {busy, done, ph}, 0);

        for (int i = 0; i < 6; i++) run_burst(VEC[i][2], VEC[i][1], VEC[i][0]);

        // reset during a burst returns to idle at once
        @(negedge clk); start = 1'b1; lsel = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(ph == 0 && !busy && !done, "R1 mid-burst reset", {busy, done, ph}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1", busy, 0);

        // start held high across completion: restart one cycle after done
        start = 1'b1; lsel = 1'b0;
        @(negedge clk);
        for (int k = 1; k < NS * 4 * Q; k++) @(negedge clk);
        @(negedge clk);
        chk(done && !busy, "R8 held start", {busy, done}, 1);
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && ph == 4'b1001, "R9 restart", {busy, done, ph}, 8'h29);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule